// File: doc/BRIEF.md
# Bitstream Density Measurement Receiver

This block takes the one-bit output stream of a delta-sigma modulator together with the modulator's own clock. Both come from outside the system-clock domain. A start strobe opens a measurement window whose length is a power of two, set by a small exponent input. During the window the block counts how many sampled bits are ones.

When the window closes, the block converts that count into a signed millivolt estimate of the modulator's differential input. The conversion assumes a linear transfer. Half ones means zero volts. Each 30 percentage points of density away from half means 256 mV.

The count and the voltage are presented together with a one-cycle valid pulse. Both stay on the outputs until the next window finishes.

Top module: `density_rx`

## Requirements
- R1: Each modulator bit is taken when the synchronized `modClk` falls. Changes on `modData` while `modClk` is high or low, away from that fall, do not alter the count.
- R2: A window spans exactly N = 2^(MIN_EXP + winExp) falling edges of `modClk` after `start`. `onesCount` then reports the number of ones among them, from 0 to N inclusive.
- R3: A `winExp` value above MAX_EXP - MIN_EXP selects the longest window, N = 2^MAX_EXP.
- R4: `resultMv` is the two's-complement value (ones - N/2) * 2560 / (3 * N), with the fraction dropped toward zero. For example, 13 ones in 16 gives +266 and 3 ones in 16 gives -266.
- R5: `valid` is high for exactly one system-clock cycle when a window's result appears. `onesCount` and `resultMv` hold their values until the next result appears.
- R6: A `start` pulse during a window or its conversion discards the partial count and begins a fresh window, and no result is produced for the abandoned window.
- R7: `resultMv` stays within -427 to +427. All ones gives +426 and all zeros gives -426.
- R8: After reset, `valid` is 0, `onesCount` is 0 and `resultMv` is 0.
- R9: Falling edges of `modClk` that arrive with no window open change no output and raise no `valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| modClk | input | 1 | Modulator bit clock, asynchronous |
| modData | input | 1 | Modulator bit stream |
| winExp | input | EXP_W | Window exponent offset above MIN_EXP |
| start | input | 1 | One-cycle strobe that opens a window |
| onesCount | output | MAX_EXP+1 | Ones counted in the last completed window |
| resultMv | output | MV_W (12) | Signed millivolt estimate |
| valid | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench builds the block with MIN_EXP = 4 and MAX_EXP = 7, so windows run from 16 to 128 bits. With these windows, the all-ones and all-zeros extremes, every legal exponent and the clamp of out-of-range exponents all fit within a short run. This keeps the modulator clock four system cycles long, which is slow enough to push bit glitches into both clock phases. It also leaves room to restart a window partway through and to send stray falling edges while no window is open.

// File: rtl/density_pkg.sv
package density_pkg;

  // Linear mapping constants: mv = (ones - N/2) * SCALE_NUM / (DIVISOR * N)
  localparam int SCALE_NUM = 2560;
  localparam int SCALE_W   = 12;
  localparam int DIVISOR   = 3;
  localparam int REM_W     = $clog2(DIVISOR);
  localparam int SAT_MV    = 427;
  // Largest magnitude before the divide is SCALE_NUM/2
  localparam int MAG_W     = $clog2(SCALE_NUM / 2 + 1);
  localparam int MV_W      = MAG_W + 1;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RUN,
    S_LOAD,
    S_DIV,
    S_PUB
  } rxState_t;

  typedef struct packed {
    logic clear;
    logic countEn;
    logic load;
    logic divStep;
    logic publish;
  } rxStrobes_t;

endpackage

// File: rtl/density_edge.sv
module density_edge (
  input  logic clk,
  input  logic rstN,
  input  logic modClk,
  input  logic modData,
  output logic fall,
  output logic bitOut
);

  logic [1:0] clkSync;
  logic [1:0] dataSync;
  logic       clkPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync  <= '0;
      dataSync <= '0;
      clkPrev  <= 1'b0;
    end else begin
      clkSync  <= {clkSync[0], modClk};
      dataSync <= {dataSync[0], modData};
      clkPrev  <= clkSync[1];
    end
  end

  assign fall   = clkPrev & ~clkSync[1];
  assign bitOut = dataSync[1];

  // R1: a fall needs a rise before the next one
  p_fall_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    fall |=> !fall);

endmodule

// File: rtl/density_ctrl.sv
module density_ctrl
  import density_pkg::*;
#(
  parameter int MIN_EXP = 8,
  parameter int MAX_EXP = 16,
  parameter int EXP_W   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [EXP_W-1:0] winExp,
  input  logic             fall,
  output rxStrobes_t       strobes,
  output logic [$clog2(MAX_EXP+1)-1:0] winShift,
  output logic             valid
);

  localparam int CNT_W  = MAX_EXP + 1;
  localparam int SH_W   = $clog2(MAX_EXP + 1);
  localparam int SPAN   = MAX_EXP - MIN_EXP;
  localparam int STEP_W = $clog2(MAG_W) + 1;

  rxState_t            state;
  logic [CNT_W-1:0]    winCnt;
  logic [CNT_W-1:0]    winLast;
  logic [STEP_W-1:0]   stepCnt;
  logic [SH_W-1:0]     shiftReq;
  logic                validQ;

  // Exponent clamp: out-of-range settings select the longest window
  always_comb begin
    int req;
    req = int'(winExp);
    if (req > SPAN) req = SPAN;
    shiftReq = SH_W'(MIN_EXP + req);
  end

  assign winLast = (CNT_W'(1) << winShift) - CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      winCnt   <= '0;
      stepCnt  <= '0;
      winShift <= SH_W'(MIN_EXP);
      validQ   <= 1'b0;
    end else begin
      validQ <= 1'b0;
      if (start) begin
        state    <= S_RUN;
        winCnt   <= '0;
        winShift <= shiftReq;
      end else begin
        unique case (state)
          S_IDLE: ;
          S_RUN: begin
            if (fall) begin
              if (winCnt == winLast) state <= S_LOAD;
              else winCnt <= winCnt + CNT_W'(1);
            end
          end
          S_LOAD: begin
            stepCnt <= '0;
            state   <= S_DIV;
          end
          S_DIV: begin
            stepCnt <= stepCnt + STEP_W'(1);
            if (stepCnt == STEP_W'(MAG_W - 1)) state <= S_PUB;
          end
          S_PUB: begin
            validQ <= 1'b1;
            state  <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strobes         = '0;
    strobes.clear   = start;
    strobes.countEn = !start && (state == S_RUN) && fall;
    strobes.load    = !start && (state == S_LOAD);
    strobes.divStep = !start && (state == S_DIV);
    strobes.publish = !start && (state == S_PUB);
  end

  assign valid = validQ;

  // R5: result strobe lasts one cycle
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    valid |=> !valid);

  // R2: window position never passes the last edge
  p_win_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN) |-> (winCnt <= winLast));

  // R9: without a start the idle state is kept
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !start) |=> (state == S_IDLE));

  // R6: a start always lands in the counting state
  p_restart_r6: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (state == S_RUN && winCnt == '0));

endmodule

// File: rtl/density_dp.sv
module density_dp
  import density_pkg::*;
#(
  parameter int MAX_EXP = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxStrobes_t       strobes,
  input  logic             bitIn,
  input  logic [$clog2(MAX_EXP+1)-1:0] winShift,
  output logic [MAX_EXP:0] onesOut,
  output logic [MV_W-1:0]  mvOut
);

  localparam int CNT_W  = MAX_EXP + 1;
  localparam int PROD_W = CNT_W + SCALE_W;

  logic [CNT_W-1:0]        onesCnt;
  logic [CNT_W-1:0]        halfN;
  logic signed [CNT_W:0]   diff;
  logic [CNT_W:0]          negDiff;
  logic [CNT_W-1:0]        mag;
  logic [PROD_W-1:0]       prod;
  logic [MAG_W-1:0]        divIn;
  logic [MAG_W-1:0]        divM;
  logic [MAG_W-1:0]        divQ;
  logic [REM_W-1:0]        divR;
  logic [REM_W:0]          trial;
  logic                    trialGe;
  logic                    negQ;
  logic [MAG_W-1:0]        qSat;

  // Ones counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) onesCnt <= '0;
    else if (strobes.clear) onesCnt <= '0;
    else if (strobes.countEn && bitIn) onesCnt <= onesCnt + CNT_W'(1);
  end

  // Offset from mid-scale, then scaled magnitude divided by N
  always_comb begin
    halfN   = CNT_W'(1) << (winShift - 1'b1);
    diff    = $signed({1'b0, onesCnt}) - $signed({1'b0, halfN});
    negDiff = -diff;
    mag     = diff[CNT_W] ? negDiff[CNT_W-1:0] : diff[CNT_W-1:0];
    prod    = PROD_W'(mag) * PROD_W'(SCALE_NUM);
    divIn   = MAG_W'(prod >> winShift);
  end

  // Serial restoring divide by the constant DIVISOR, one quotient bit per cycle
  always_comb begin
    trial   = {divR, divM[MAG_W-1]};
    trialGe = trial >= (REM_W+1)'(DIVISOR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divM <= '0;
      divQ <= '0;
      divR <= '0;
      negQ <= 1'b0;
    end else if (strobes.load) begin
      divM <= divIn;
      divQ <= '0;
      divR <= '0;
      negQ <= diff[CNT_W];
    end else if (strobes.divStep) begin
      divM <= divM << 1;
      divQ <= {divQ[MAG_W-2:0], trialGe};
      divR <= trialGe ? REM_W'(trial - (REM_W+1)'(DIVISOR)) : trial[REM_W-1:0];
    end
  end

  assign qSat = (divQ > MAG_W'(SAT_MV)) ? MAG_W'(SAT_MV) : divQ;

  // Published results
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      onesOut <= '0;
      mvOut   <= '0;
    end else if (strobes.publish) begin
      onesOut <= onesCnt;
      mvOut   <= negQ ? -{1'b0, qSat} : {1'b0, qSat};
    end
  end

  // R7: the published voltage stays inside the clamp
  p_sat_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($signed(mvOut) <= $signed(MV_W'(SAT_MV))) &&
    ($signed(mvOut) >= -$signed(MV_W'(SAT_MV))));

  // R5: outputs only move on a publish
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.publish |=> ($stable(onesOut) && $stable(mvOut)));

  // R2: the counter never exceeds the window length
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clear |-> (onesCnt <= (CNT_W'(1) << winShift)));

endmodule

// File: rtl/density_rx.sv
module density_rx
  import density_pkg::*;
#(
  parameter int MIN_EXP = 8,
  parameter int MAX_EXP = 16,
  parameter int EXP_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                modClk,
  input  logic                modData,
  input  logic [EXP_W-1:0]    winExp,
  input  logic                start,
  output logic [MAX_EXP:0]    onesCount,
  output logic [MV_W-1:0]     resultMv,
  output logic                valid
);

  localparam int SH_W = $clog2(MAX_EXP + 1);

  logic            fall;
  logic            bitIn;
  rxStrobes_t      strobes;
  logic [SH_W-1:0] winShift;

  density_edge u_edge (
    .clk     (clk),
    .rstN    (rstN),
    .modClk  (modClk),
    .modData (modData),
    .fall    (fall),
    .bitOut  (bitIn)
  );

  density_ctrl #(
    .MIN_EXP (MIN_EXP),
    .MAX_EXP (MAX_EXP),
    .EXP_W   (EXP_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .winExp   (winExp),
    .fall     (fall),
    .strobes  (strobes),
    .winShift (winShift),
    .valid    (valid)
  );

  density_dp #(
    .MAX_EXP (MAX_EXP)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .bitIn    (bitIn),
    .winShift (winShift),
    .onesOut  (onesCount),
    .mvOut    (resultMv)
  );

endmodule

// File: tb/test_density_rx.sv
module test_density_rx;

  localparam int MIN_EXP = 4;
  localparam int MAX_EXP = 7;
  localparam int EXP_W   = 4;
  localparam int MV_W    = density_pkg::MV_W;
  localparam int NV      = 9;

  localparam int VEC_EXP   [NV] = '{0, 0, 0, 1, 1, 2, 2, 3, 3};
  localparam int VEC_ONES  [NV] = '{8, 13, 3, 32, 0, 40, 25, 77, 51};
  localparam int VEC_SPRD  [NV] = '{1, 0, 1, 0, 0, 1, 0, 1, 0};
  localparam int VEC_GLITCH[NV] = '{0, 1, 0, 0, 1, 0, 1, 0, 0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modClk = 1'b0;
  logic modData = 1'b0;
  logic [EXP_W-1:0] winExp = '0;
  logic start = 1'b0;
  logic [MAX_EXP:0] onesCount;
  logic [MV_W-1:0]  resultMv;
  logic valid;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  density_rx #(.MIN_EXP(MIN_EXP), .MAX_EXP(MAX_EXP), .EXP_W(EXP_W)) i_density_rx (
    .clk(clk), .rstN(rstN), .modClk(modClk), .modData(modData),
    .winExp(winExp), .start(start),
    .onesCount(onesCount), .resultMv(resultMv), .valid(valid)
  );

  function automatic int expMv(int ones, int n);
    int q;
    q = ((ones - n / 2) * 2560) / (3 * n);
    if (q > 427) q = 427;
    if (q < -427) q = -427;
    return q;
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic modCycle(logic b, bit glitch);
    @(negedge clk); modData = glitch ? ~b : b; modClk = 1'b1;
    @(negedge clk); modData = b;
    @(negedge clk); modClk = 1'b0;
    @(negedge clk); modData = glitch ? ~b : b;
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic runWindow(int n, int ones, bit spread, bit glitch);
    for (int i = 0; i < n; i++) begin
      logic b;
      if (spread) b = (((i + 1) * ones) / n) != ((i * ones) / n);
      else b = (i < ones);
      modCycle(b, glitch);
    end
  endtask

  task automatic waitValid(output bit got);
    got = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (valid) begin got = 1; break; end
    end
  endtask

  task automatic checkResult(string tag, int n, int ones);
    bit got;
    waitValid(got);
    check(got, {tag, " R5 valid seen"}, int'(got), 1);
    check(int'(onesCount) == ones, {tag, " R2 count"}, int'(onesCount), ones);
    check(int'($signed(resultMv)) == expMv(ones, n), {tag, " R4 R7 mv"},
          int'($signed(resultMv)), expMv(ones, n));
    @(negedge clk);
    check(valid == 1'b0, {tag, " R5 valid one cycle"}, int'(valid), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R8 reset state
    check(valid == 1'b0, "R8 valid", int'(valid), 0);
    check(onesCount == '0, "R8 count", int'(onesCount), 0);
    check(resultMv == '0, "R8 mv", int'($signed(resultMv)), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // Vector table: R1 glitches, R2 windows, R4 rounding, R7 extremes
    for (int v = 0; v < NV; v++) begin
      int n;
      n = 1 << (MIN_EXP + VEC_EXP[v]);
      winExp = EXP_W'(VEC_EXP[v]);
      pulseStart();
      runWindow(n, VEC_ONES[v], VEC_SPRD[v] != 0, VEC_GLITCH[v] != 0);
      checkResult($sformatf("vec%0d%s", v, VEC_GLITCH[v] != 0 ? " R1" : ""), n, VEC_ONES[v]);
    end

    // R9 and R5 hold: falls with no window open
    begin
      logic [MAX_EXP:0] keepCnt;
      logic [MV_W-1:0] keepMv;
      bit sawValid;
      keepCnt = onesCount; keepMv = resultMv; sawValid = 0;
      for (int i = 0; i < 20; i++) begin
        modCycle(1'b1, 1'b0);
        if (valid) sawValid = 1;
      end
      repeat (40) begin @(negedge clk); if (valid) sawValid = 1; end
      check(!sawValid, "R9 no valid while idle", int'(sawValid), 0);
      check(onesCount == keepCnt, "R5 R9 count held", int'(onesCount), int'(keepCnt));
      check(resultMv == keepMv, "R5 R9 mv held", int'($signed(resultMv)), int'($signed(keepMv)));
    end

    // R6 restart mid-window
    winExp = 4'd0;
    pulseStart();
    runWindow(10, 10, 1'b0, 1'b0);
    pulseStart();
    runWindow(16, 3, 1'b0, 1'b0);
    checkResult("R6 restart", 16, 3);

    // R3 exponent clamp to longest window
    winExp = 4'd9;
    pulseStart();
    runWindow(128, 128, 1'b0, 1'b0);
    checkResult("R3 clamp", 128, 128);
    check(int'($signed(resultMv)) == 426, "R7 full scale", int'($signed(resultMv)), 426);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule